// File: doc/BRIEF.md
# Four-Times Polyphase Root-Raised-Cosine Interpolator

This block shapes one I/Q pair of baseband symbols for transmission. Signed 8-bit I and Q symbols arrive at one quarter of the clock rate, each marked by a one-cycle strobe. The block turns them into 24-bit filtered samples at the full clock rate. The result is a pulse-shaped stream whose spectrum has the adjacent-channel energy of the raw symbol steps removed.

The filter is a fixed 24-tap root-raised-cosine prototype. It is split into four 6-tap phases, so only the stored symbols are multiplied and no inserted zeros are processed. Each accepted symbol restarts the phase sequence. Every following clock produces the next phase of the interpolated output. I and Q pass through identical lanes, so the two outputs carry the same latency.

Top module: `rrc_interp`

## Requirements
- R1: While reset (`rstN` low) is applied and on the first clock after it, `outValid` is 0 and `outI` and `outQ` are 0. Every stored symbol is cleared to zero.
- R2: A symbol is taken into the six-deep history only on a rising clock edge where `symValid` is 1. Values on `symI`/`symQ` at any other edge do not change later outputs.
- R3: Let the symbols be taken at edge t, with x0 the newest and x5 the oldest, and let p be the phase. The output registered at edge t+1+p is the sum over j=0..5 of h[4j+p]*xj, where p counts 0,1,2,3.
- R4: The coefficients are signed 12-bit integers with h[23-i] = h[i]. For i=0..11, h[i] is 40, 100, 110, 10, -160, -300, -280, -30, 420, 1000, 1550, 1900.
- R5: `outValid` stays 0 until six symbols have been taken since reset. It goes to 1 on the clock edge after the sixth accepted symbol and stays 1 on every clock after that.
- R6: I and Q use the same coefficients and the same latency. Equal I and Q symbol streams give equal `outI` and `outQ` on every cycle, and negated streams give negated outputs.
- R7: The outputs are exact, with no overflow or wrap, for full-scale inputs (-128 and +127) on every tap. Each output is the two's-complement 24-bit value of the sum.
- R8: The phase index returns to 0 on each accepted symbol. Without a new symbol it advances by one each clock modulo 4, so long gaps repeat phases 0..3 over the same history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Symbol strobe; the symbol is taken on this edge |
| symI | input | 8 | Signed in-phase symbol |
| symQ | input | 8 | Signed quadrature symbol |
| outValid | output | 1 | History primed; output sample valid |
| outI | output | 24 | Filtered in-phase sample |
| outQ | output | 24 | Filtered quadrature sample |

## Verification
A single unit impulse on I, with a negative impulse on Q, walks the whole coefficient set out in order. This tells apart a wrong phase-to-tap mapping, a broken symmetry and a sign error between the lanes. Full-scale constant symbols test the accumulator width. A pseudo-random stream with equal I and Q shows any lane mismatch, and a stream with differing I and Q shows crossed lanes. Idle cycles that carry changing symbol values, together with gaps longer and shorter than four cycles, separate a correct capture strobe and phase restart from a free-running phase counter.

// File: rtl/rrc_interp_pkg.sv
package rrc_interp_pkg;
  localparam int NUM_TAPS   = 24;
  localparam int INTERP     = 4;
  localparam int PHASE_TAPS = NUM_TAPS / INTERP;
  localparam int COEF_W     = 12;
  localparam int PHASE_W    = $clog2(INTERP);
  localparam int HALF_TAPS  = NUM_TAPS / 2;

  // Outer half of the symmetric prototype, outermost tap first.
  localparam logic signed [COEF_W-1:0] HALF_COEF [HALF_TAPS] = '{
    12'sd40, 12'sd100, 12'sd110, 12'sd10, -12'sd160, -12'sd300,
    -12'sd280, -12'sd30, 12'sd420, 12'sd1000, 12'sd1550, 12'sd1900
  };

  function automatic logic signed [COEF_W-1:0] coefAt(input int idx);
    if (idx < HALF_TAPS) return HALF_COEF[idx];
    return HALF_COEF[NUM_TAPS-1-idx];
  endfunction

  typedef struct packed {
    logic               load;
    logic [PHASE_W-1:0] phase;
    logic               primed;
  } ctrl_t;
endpackage

// File: rtl/rrc_interp_ctrl.sv
module rrc_interp_ctrl
  import rrc_interp_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  symValid,
  output ctrl_t ctrlBus
);
  localparam int FILL_W = $clog2(PHASE_TAPS + 1);

  logic [PHASE_W-1:0] phaseQ;
  logic [FILL_W-1:0]  fillQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
      fillQ  <= '0;
    end else if (symValid) begin
      phaseQ <= '0;
      if (fillQ != FILL_W'(PHASE_TAPS)) fillQ <= fillQ + 1'b1;
    end else begin
      phaseQ <= phaseQ + 1'b1;
    end
  end

  assign ctrlBus.load   = symValid;
  assign ctrlBus.phase  = phaseQ;
  assign ctrlBus.primed = (fillQ == FILL_W'(PHASE_TAPS));
endmodule

// File: rtl/rrc_interp_lane.sv
module rrc_interp_lane
  import rrc_interp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_t                    ctrlBus,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [OUT_W-1:0]  result
);
  localparam int ACC_W = DATA_W + COEF_W + $clog2(PHASE_TAPS);

  logic signed [DATA_W-1:0] hist [PHASE_TAPS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [OUT_W-1:0]  shaped;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHASE_TAPS; i++) hist[i] <= '0;
    end else if (ctrlBus.load) begin
      hist[0] <= sample;
      for (int i = 1; i < PHASE_TAPS; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < PHASE_TAPS; j++) begin
      acc = acc + ACC_W'(hist[j]) * ACC_W'(coefAt(j * INTERP + int'(ctrlBus.phase)));
    end
  end

  generate
    if (ACC_W <= OUT_W) begin : g_extend
      assign shaped = OUT_W'(acc);
    end else begin : g_round
      localparam int DROP = ACC_W - OUT_W;
      logic signed [ACC_W:0] rnd;
      assign rnd    = {acc[ACC_W-1], acc} + ((ACC_W+1)'(1) << (DROP - 1));
      assign shaped = rnd[OUT_W+DROP-1:DROP];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) result <= '0;
    else       result <= shaped;
  end
endmodule

// File: rtl/rrc_interp_datapath.sv
module rrc_interp_datapath
  import rrc_interp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrlBus,
  input  logic [DATA_W-1:0] symI,
  input  logic [DATA_W-1:0] symQ,
  output logic              outValid,
  output logic [OUT_W-1:0]  outI,
  output logic [OUT_W-1:0]  outQ
);
  localparam int LANES = 2;

  logic [LANES-1:0][DATA_W-1:0] laneIn;
  logic [LANES-1:0][OUT_W-1:0]  laneOut;

  assign laneIn = {symQ, symI};

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      rrc_interp_lane #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_lane (
        .clk    (clk),
        .rstN   (rstN),
        .ctrlBus(ctrlBus),
        .sample (laneIn[g]),
        .result (laneOut[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= ctrlBus.primed;
  end

  assign outI = laneOut[0];
  assign outQ = laneOut[1];
endmodule

// File: rtl/rrc_interp.sv
module rrc_interp
  import rrc_interp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              symValid,
  input  logic [DATA_W-1:0] symI,
  input  logic [DATA_W-1:0] symQ,
  output logic              outValid,
  output logic [OUT_W-1:0]  outI,
  output logic [OUT_W-1:0]  outQ
);
  ctrl_t ctrlBus;

  rrc_interp_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .symValid(symValid),
    .ctrlBus (ctrlBus)
  );

  rrc_interp_datapath #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlBus (ctrlBus),
    .symI    (symI),
    .symQ    (symQ),
    .outValid(outValid),
    .outI    (outI),
    .outQ    (outQ)
  );
endmodule

// File: rtl/rrc_interp_checker.sv
module rrc_interp_checker
  import rrc_interp_pkg::*;
(
  input logic  clk,
  input logic  rstN,
  input logic  symValid,
  input logic  outValid,
  input ctrl_t ctrlBus
);
  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> outValid);

  assert_valid_follows_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(symValid, 2));

  assert_unprimed_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBus.primed |=> !outValid);

  assert_phase_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    symValid |=> (ctrlBus.phase == '0));

  assert_phase_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> (ctrlBus.phase == PHASE_W'($past(ctrlBus.phase) + 1'b1)));
endmodule

bind rrc_interp rrc_interp_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .symValid(symValid),
  .outValid(outValid),
  .ctrlBus (ctrlBus)
);

// File: tb/tb_rrc_interp.sv
module tb_rrc_interp;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        symValid = 1'b0;
  logic [7:0]  symI = '0;
  logic [7:0]  symQ = '0;
  logic        outValid;
  logic [23:0] outI;
  logic [23:0] outQ;

  int checks = 0;
  int errors = 0;

  int mHistI [6];
  int mHistQ [6];
  int mPhase = 0;
  int mFill = 0;
  int lfsr = 16'hACE1;

  always #10 clk = ~clk;

  rrc_interp dut (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symI(symI), .symQ(symQ),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  function automatic int coefB(input int idx);
    int half [12] = '{40, 100, 110, 10, -160, -300, -280, -30, 420, 1000, 1550, 1900};
    return (idx < 12) ? half[idx] : half[23 - idx];
  endfunction

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int j = 0; j < 6; j++) begin
      mHistI[j] = 0;
      mHistQ[j] = 0;
    end
    mPhase = 0;
    mFill = 0;
  endtask

  // Entered at a falling edge; drives one cycle and checks the outputs
  // registered at the next rising edge.
  task automatic tick(input bit v, input int i, input int q, input string tag);
    int expI = 0;
    int expQ = 0;
    int expV;
    for (int j = 0; j < 6; j++) begin
      expI += coefB(4 * j + mPhase) * mHistI[j];
      expQ += coefB(4 * j + mPhase) * mHistQ[j];
    end
    expV = (mFill == 6) ? 1 : 0;
    symValid = v;
    symI = i[7:0];
    symQ = q[7:0];
    if (v) begin
      for (int j = 5; j > 0; j--) begin
        mHistI[j] = mHistI[j-1];
        mHistQ[j] = mHistQ[j-1];
      end
      mHistI[0] = int'($signed(i[7:0]));
      mHistQ[0] = int'($signed(q[7:0]));
      mPhase = 0;
      if (mFill < 6) mFill++;
    end else begin
      mPhase = (mPhase + 1) % 4;
    end
    @(negedge clk);
    checkEq({tag, " outValid"}, int'(outValid), expV);
    checkEq({tag, " outI"}, $signed(outI), expI);
    checkEq({tag, " outQ"}, $signed(outQ), expQ);
  endtask

  task automatic sendSym(input int i, input int q, input int idle, input string tag);
    tick(1'b1, i, q, tag);
    for (int k = 0; k < idle; k++) tick(1'b0, i + k + 1, q - k - 1, tag);
  endtask

  task automatic nextRand(output int val);
    lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
    val = (lfsr & 8'hFF) - 128;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    symValid = 1'b1;
    symI = 8'h55;
    symQ = 8'hAA;
    repeat (3) @(negedge clk);
    checkEq("R1 outValid in reset", int'(outValid), 0);
    checkEq("R1 outI in reset", $signed(outI), 0);
    checkEq("R1 outQ in reset", $signed(outQ), 0);
    symValid = 1'b0;
    rstN = 1'b1;
    modelReset();
    tick(1'b0, 0, 0, "R1 first cycle");
  endtask

  task automatic testPriming();
    testReset();
    for (int n = 0; n < 8; n++) sendSym(n + 3, -n, 3, "R5 priming");
  endtask

  task automatic testImpulse();
    testReset();
    sendSym(1, -1, 3, "R4 impulse");
    for (int n = 0; n < 6; n++) sendSym(0, 0, 3, "R3 R4 R6 impulse tail");
  endtask

  task automatic testIgnore();
    testReset();
    for (int n = 0; n < 7; n++) begin
      tick(1'b1, 20 * n - 60, 50 - 9 * n, "R2 load");
      tick(1'b0, 127, -128, "R2 idle wiggle");
      tick(1'b0, -128, 127, "R2 idle wiggle");
      tick(1'b0, 85, -86, "R2 idle wiggle");
    end
  endtask

  task automatic testFullScale();
    testReset();
    for (int n = 0; n < 8; n++) sendSym(-128, 127, 3, "R7 full scale");
    for (int n = 0; n < 7; n++) sendSym(127, -128, 3, "R7 full scale swap");
  endtask

  task automatic testStreams();
    int a;
    int b;
    testReset();
    for (int n = 0; n < 20; n++) begin
      nextRand(a);
      tick(1'b1, a, a, "R6 equal lanes");
      for (int k = 0; k < 3; k++) begin
        tick(1'b0, a, a, "R6 equal lanes");
        checkEq("R6 outI==outQ", $signed(outI), $signed(outQ));
      end
    end
    for (int n = 0; n < 20; n++) begin
      nextRand(a);
      nextRand(b);
      sendSym(a, b, 3, "R3 random");
    end
  endtask

  task automatic testPhaseWrap();
    testReset();
    for (int n = 0; n < 6; n++) sendSym(10 * n - 25, 7 - 3 * n, 3, "R8 prime");
    sendSym(90, -70, 9, "R8 long gap");
    sendSym(-40, 33, 1, "R8 short gap");
    sendSym(15, -15, 0, "R8 back to back");
    sendSym(-99, 64, 6, "R8 restart");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion of all scenarios");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testPriming();
    testImpulse();
    testIgnore();
    testFullScale();
    testStreams();
    testPhaseWrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule